// File: doc/BRIEF.md
# Frame-Reserving Subroutine Stack Unit

This block is the stack engine of a small processor. It keeps a word-wide stack in a local register file, together with a stack pointer and a frame pointer. Each clock it carries out one stack operation from the decoder. The operations are a push of an operand, a pop of the top word, a frame mark that reserves a return-address slot, a call into a subroutine and a return from it. The operand input carries either a literal or the contents of a register; the decoder selects which one before the operand reaches the block. On a pop, the popped word is handed back for the register file to write. For every operation the block reports the program counter to fetch from next.

The stack grows toward lower addresses. The stack pointer names the current top entry, and it equals the depth when the stack is empty. A caller first marks a frame. The mark pushes the previous frame pointer and an empty slot, and the frame pointer then names that slot. The caller may then push parameters, such as a loop count, and finally calls. The call writes the call's own address plus one into the reserved slot, not onto the top. This leaves the parameters on top, so the callee can fetch them with ordinary pops. A return reloads the program counter from the slot and restores the previous frame pointer. It also discards the frame, including any words the callee left on it. Frames nest to any depth that the storage allows.

Top module: `stk_unit`

## Requirements
- R1: After reset the stack pointer reads DEPTH (empty), the next-PC output reads 0, and the pop-valid, underflow and overflow outputs are 0.
- R2: Opcode 1 (push) with at least one free entry stores the operand as the new top. The stack pointer drops by 1 and the next PC is the current PC plus 1.
- R3: A push when no entry is free, or opcode 3 (mark) when fewer than two entries are free, raises overflow for one cycle. The stack pointer and the stored contents stay unchanged.
- R4: Opcode 2 (pop) on a non-empty stack returns the top word with pop-valid high for one cycle and raises the stack pointer by 1. Pops come back in last-in, first-out order.
- R5: A pop on an empty stack raises underflow for one cycle. Pop-valid stays low, the popped-data output reads 0, and the stack pointer does not change.
- R6: Opcode 3 (mark) with two free entries lowers the stack pointer by 2 and opens a new frame.
- R7: Opcode 4 (call) with an open frame makes the next PC equal the target address and leaves the stack pointer unchanged. The current PC plus 1 goes into the reserved slot of the open frame.
- R8: Words pushed between a mark and its call come back to the callee through ordinary pops, in last-in, first-out order. These pops do not disturb the stored return address.
- R9: Opcode 5 (return) with an open frame makes the next PC equal the address stored by the matching call. It returns the stack pointer to its value before the mark and reopens the caller's frame.
- R10: Calls nested eight deep return in reverse order, each to its own call address plus 1, with the stack pointer restored at each level.
- R11: A call or return while no frame is open raises underflow for one cycle. The next PC is the current PC plus 1 and the stack pointer does not change.
- R12: Opcode 0 and the unused opcodes 6 and 7 leave the stack unchanged. They give a next PC equal to the current PC plus 1 and keep all three flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Stack operation code: 0 none, 1 push, 2 pop, 3 mark, 4 call, 5 return |
| operand_i | input | DATA_W | Literal or register value to push |
| pc_i | input | DATA_W | Address of the current instruction |
| target_i | input | DATA_W | Subroutine entry address for a call |
| pop_data_o | output | DATA_W | Word taken off the top by a pop |
| pop_valid_o | output | 1 | Pop data is valid this cycle |
| next_pc_o | output | DATA_W | Address to fetch next |
| sp_o | output | SP_W | Stack pointer; DEPTH means empty |
| underflow_o | output | 1 | Pop on an empty stack, or call/return with no open frame |
| overflow_o | output | 1 | Push or mark refused for lack of room |

## Verification
Push and pop are tried with distinct word patterns, including an all-ones-heavy value and a full fill of the storage with a counting sequence. This separates a wrong last-in, first-out order from lost or duplicated entries. The boundaries are driven from both ends: pops on an empty stack, pushes into a full stack, and a mark with exactly one free entry. These show whether refused operations really leave the pointer and the contents alone. Single calls with a parameter, and an eight-deep nest that leaves its parameters unpopped, separate a return address kept in the reserved slot from one taken off the top of the stack. Returns and calls with no open frame, and the unused opcodes, confirm that error and idle cases still advance the PC by one.

// File: rtl/stk_unit_pkg.sv
package stk_unit_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_MARK = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5
  } stk_op_e;
endpackage

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic [DATA_W-1:0] wa_dat,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_dat,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_dat,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_dat
);
  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wa_en && wa_idx == IDX_W'(g))      cells[g] <= wa_dat;
      else if (wb_en && wb_idx == IDX_W'(g)) cells[g] <= wb_dat;
    end
  end

  assign ra_dat = cells[ra_idx];
  assign rb_dat = cells[rb_idx];

  // Write ports never collide when the controller behaves.
  always @(posedge clk) begin
    if (wa_en && wb_en)
      a_no_port_clash_r6: assert (wa_idx != wb_idx)
        else $error("write ports collide");
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_unit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] target_i,
  // storage side
  output logic              wa_en,
  output logic [IDX_W-1:0]  wa_idx,
  output logic [DATA_W-1:0] wa_dat,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_dat,
  output logic [IDX_W-1:0]  ra_idx,
  input  logic [DATA_W-1:0] ra_dat,
  output logic [IDX_W-1:0]  rb_idx,
  input  logic [DATA_W-1:0] rb_dat,
  // events and results
  output logic              pop_ok,
  output logic              underflow_evt,
  output logic              overflow_evt,
  output logic [DATA_W-1:0] pc_nxt,
  output logic [SP_W-1:0]   sp_q,
  output logic [SP_W-1:0]   fp_q
);
  localparam logic [SP_W-1:0] EMPTY = SP_W'(DEPTH);

  function automatic logic has_room(input logic [SP_W-1:0] sp, input int need);
    return int'(sp) >= need;
  endfunction

  function automatic logic [DATA_W-1:0] ret_addr(input logic [DATA_W-1:0] pc);
    return pc + DATA_W'(1);
  endfunction

  logic is_push, is_pop, is_mark, is_call, is_ret;
  logic push_ok, push_ovf, pop_unf, mark_ok, mark_ovf;
  logic has_frame, call_ok, ret_ok, frame_err;
  logic [SP_W-1:0] sp_d, fp_d, sp_m1, sp_m2;

  assign is_push = op_i == OP_PUSH;
  assign is_pop  = op_i == OP_POP;
  assign is_mark = op_i == OP_MARK;
  assign is_call = op_i == OP_CALL;
  assign is_ret  = op_i == OP_RET;

  assign sp_m1 = sp_q - SP_W'(1);
  assign sp_m2 = sp_q - SP_W'(2);

  assign push_ok   = is_push && has_room(sp_q, 1);
  assign push_ovf  = is_push && !has_room(sp_q, 1);
  assign pop_ok    = is_pop && sp_q != EMPTY;
  assign pop_unf   = is_pop && sp_q == EMPTY;
  assign mark_ok   = is_mark && has_room(sp_q, 2);
  assign mark_ovf  = is_mark && !has_room(sp_q, 2);
  assign has_frame = fp_q != EMPTY;
  assign call_ok   = is_call && has_frame;
  assign ret_ok    = is_ret && has_frame;
  assign frame_err = (is_call || is_ret) && !has_frame;

  assign underflow_evt = pop_unf || frame_err;
  assign overflow_evt  = push_ovf || mark_ovf;

  // Read port A: top of stack for a pop, reserved slot otherwise.
  assign ra_idx = is_pop ? IDX_W'(sp_q) : IDX_W'(fp_q);
  // Read port B: saved frame pointer just below the reserved slot.
  assign rb_idx = IDX_W'(fp_q + SP_W'(1));

  always_comb begin
    wa_en  = 1'b0;
    wa_idx = IDX_W'(sp_m1);
    wa_dat = operand_i;
    wb_en  = 1'b0;
    wb_idx = IDX_W'(sp_m2);
    wb_dat = '0;
    if (push_ok) begin
      wa_en = 1'b1;
    end else if (mark_ok) begin
      wa_en  = 1'b1;
      wa_dat = DATA_W'(fp_q);
      wb_en  = 1'b1;
    end else if (call_ok) begin
      wa_en  = 1'b1;
      wa_idx = IDX_W'(fp_q);
      wa_dat = ret_addr(pc_i);
    end
  end

  always_comb begin
    sp_d   = sp_q;
    fp_d   = fp_q;
    pc_nxt = ret_addr(pc_i);
    if (push_ok) sp_d = sp_m1;
    if (pop_ok)  sp_d = sp_q + SP_W'(1);
    if (mark_ok) begin
      sp_d = sp_m2;
      fp_d = sp_m2;
    end
    if (call_ok) pc_nxt = target_i;
    if (ret_ok) begin
      sp_d   = fp_q + SP_W'(2);
      fp_d   = SP_W'(rb_dat);
      pc_nxt = ra_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= EMPTY;
      fp_q <= EMPTY;
    end else begin
      sp_q <= sp_d;
      fp_q <= fp_d;
    end
  end

  p_sp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= EMPTY);

  p_push_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> sp_q == $past(sp_q) - SP_W'(1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_evt |=> $stable(sp_q) && $stable(fp_q));

  p_mark_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_ok |=> sp_q == $past(sp_q) - SP_W'(2) && fp_q == sp_q);

  p_call_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    call_ok |=> $stable(sp_q) && $stable(fp_q));

  p_ret_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> sp_q == $past(fp_q) + SP_W'(2));

  p_frame_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> $stable(sp_q));
endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_unit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] target_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] next_pc_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              underflow_o,
  output logic              overflow_o
);
  logic              wa_en, wb_en;
  logic [IDX_W-1:0]  wa_idx, wb_idx, ra_idx, rb_idx;
  logic [DATA_W-1:0] wa_dat, wb_dat, ra_dat, rb_dat;
  logic              pop_ok, underflow_evt, overflow_evt;
  logic [DATA_W-1:0] pc_nxt;
  logic [SP_W-1:0]   sp_q, fp_q;

  stk_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .wa_en (wa_en),  .wa_idx(wa_idx), .wa_dat(wa_dat),
    .wb_en (wb_en),  .wb_idx(wb_idx), .wb_dat(wb_dat),
    .ra_idx(ra_idx), .ra_dat(ra_dat),
    .rb_idx(rb_idx), .rb_dat(rb_dat)
  );

  stk_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .operand_i    (operand_i),
    .pc_i         (pc_i),
    .target_i     (target_i),
    .wa_en        (wa_en),  .wa_idx(wa_idx), .wa_dat(wa_dat),
    .wb_en        (wb_en),  .wb_idx(wb_idx), .wb_dat(wb_dat),
    .ra_idx       (ra_idx), .ra_dat(ra_dat),
    .rb_idx       (rb_idx), .rb_dat(rb_dat),
    .pop_ok       (pop_ok),
    .underflow_evt(underflow_evt),
    .overflow_evt (overflow_evt),
    .pc_nxt       (pc_nxt),
    .sp_q         (sp_q),
    .fp_q         (fp_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_data_o  <= '0;
      pop_valid_o <= 1'b0;
      next_pc_o   <= '0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      pop_data_o  <= pop_ok ? ra_dat : '0;
      pop_valid_o <= pop_ok;
      next_pc_o   <= pc_nxt;
      underflow_o <= underflow_evt;
      overflow_o  <= overflow_evt;
    end
  end

  assign sp_o = sp_q;

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_valid_o, underflow_o, overflow_o}));

  p_underflow_nodata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> pop_data_o == '0);

  p_call_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CALL && fp_q != SP_W'(DEPTH)) |=> next_pc_o == $past(target_i));

  p_idle_pc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NOP) |=> next_pc_o == $past(pc_i) + DATA_W'(1) && $stable(sp_o));
endmodule

// File: tb/test_stk_unit.sv
module test_stk_unit;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 32;
  localparam int SP_W   = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        op_i = 3'd0;
  logic [DATA_W-1:0] operand_i = '0, pc_i = '0, target_i = '0;
  logic [DATA_W-1:0] pop_data_o, next_pc_o;
  logic              pop_valid_o, underflow_o, overflow_o;
  logic [SP_W-1:0]   sp_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  stk_unit #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_stk_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .operand_i(operand_i),
    .pc_i(pc_i), .target_i(target_i), .pop_data_o(pop_data_o),
    .pop_valid_o(pop_valid_o), .next_pc_o(next_pc_o), .sp_o(sp_o),
    .underflow_o(underflow_o), .overflow_o(overflow_o)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Apply one operation, let one edge take it, then return to idle.
  task automatic issue(input int op, input int opnd, input int pc, input int tgt);
    op_i = 3'(op); operand_i = DATA_W'(opnd);
    pc_i = DATA_W'(pc); target_i = DATA_W'(tgt);
    @(posedge clk); #1;
    op_i = 3'd0;
  endtask

  task automatic t_reset;
    check("R1", "sp", int'(sp_o), DEPTH);
    check("R1", "next_pc", int'(next_pc_o), 0);
    check("R1", "flags", {pop_valid_o, underflow_o, overflow_o}, 0);
  endtask

  task automatic t_push_pop;
    int vals [3] = '{16'h1111, 16'h2222, 16'hABCD};
    for (int i = 0; i < 3; i++) begin
      issue(1, vals[i], 40 + i, 0);
      check("R2", "sp after push", int'(sp_o), DEPTH - 1 - i);
      check("R2", "next_pc", int'(next_pc_o), 41 + i);
    end
    for (int i = 2; i >= 0; i--) begin
      issue(2, 0, 50, 0);
      check("R4", "pop data", int'(pop_data_o), vals[i]);
      check("R4", "pop valid", int'(pop_valid_o), 1);
      check("R4", "sp after pop", int'(sp_o), DEPTH - i);
    end
  endtask

  task automatic t_underflow;
    issue(2, 0, 7, 0);
    check("R5", "underflow", int'(underflow_o), 1);
    check("R5", "pop valid", int'(pop_valid_o), 0);
    check("R5", "pop data", int'(pop_data_o), 0);
    check("R5", "sp", int'(sp_o), DEPTH);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < DEPTH; i++) issue(1, i * 3 + 7, 0, 0);
    check("R3", "sp full", int'(sp_o), 0);
    issue(1, 16'hDEAD, 0, 0);
    check("R3", "overflow on push", int'(overflow_o), 1);
    check("R3", "sp held", int'(sp_o), 0);
    issue(3, 0, 0, 0);
    check("R3", "overflow on mark", int'(overflow_o), 1);
    issue(2, 0, 0, 0);
    check("R3", "top kept", int'(pop_data_o), (DEPTH - 1) * 3 + 7);
    check("R3", "overflow cleared", int'(overflow_o), 0);
    issue(3, 0, 0, 0);
    check("R3", "mark with one free", int'(overflow_o), 1);
    check("R3", "sp after refused mark", int'(sp_o), 1);
    for (int i = DEPTH - 2; i >= 0; i--) begin
      issue(2, 0, 0, 0);
      check("R4", "drain order", int'(pop_data_o), i * 3 + 7);
    end
    check("R4", "empty after drain", int'(sp_o), DEPTH);
  endtask

  task automatic t_call_ret;
    issue(3, 0, 100, 0);
    check("R6", "sp after mark", int'(sp_o), DEPTH - 2);
    issue(1, 8, 101, 0);
    issue(1, 5, 102, 0);
    issue(4, 0, 103, 200);
    check("R7", "call next_pc", int'(next_pc_o), 200);
    check("R7", "call sp", int'(sp_o), DEPTH - 4);
    issue(2, 0, 200, 0);
    check("R8", "first param", int'(pop_data_o), 5);
    issue(2, 0, 201, 0);
    check("R8", "second param", int'(pop_data_o), 8);
    issue(5, 0, 202, 0);
    check("R9", "return pc", int'(next_pc_o), 104);
    check("R9", "sp restored", int'(sp_o), DEPTH);
    issue(5, 0, 300, 0);
    check("R11", "frame closed", int'(underflow_o), 1);
  endtask

  task automatic t_nested;
    for (int k = 0; k < 8; k++) begin
      issue(3, 0, 10 * k, 0);
      issue(1, 16'h0F00 + k, 10 * k + 1, 0);
      issue(4, 0, 10 * k + 2, 1000 + k);
      check("R10", "nested target", int'(next_pc_o), 1000 + k);
    end
    check("R10", "sp at depth 8", int'(sp_o), DEPTH - 24);
    for (int k = 7; k >= 0; k--) begin
      issue(5, 0, 1000 + k, 0);
      check("R10", "nested return", int'(next_pc_o), 10 * k + 3);
      check("R10", "nested sp", int'(sp_o), DEPTH - 3 * k);
    end
  endtask

  task automatic t_frame_err;
    issue(5, 0, 500, 0);
    check("R11", "ret no frame", int'(underflow_o), 1);
    check("R11", "ret pc", int'(next_pc_o), 501);
    issue(4, 0, 600, 900);
    check("R11", "call no frame", int'(underflow_o), 1);
    check("R11", "call pc", int'(next_pc_o), 601);
    check("R11", "sp", int'(sp_o), DEPTH);
  endtask

  task automatic t_idle;
    issue(1, 77, 0, 0);
    for (int o = 6; o <= 8; o++) begin
      issue(o == 8 ? 0 : o, 55, 700 + o, 900);
      check("R12", "idle pc", int'(next_pc_o), 701 + o);
      check("R12", "idle sp", int'(sp_o), DEPTH - 1);
      check("R12", "idle flags", {pop_valid_o, underflow_o, overflow_o}, 0);
    end
    issue(2, 0, 0, 0);
    check("R12", "top untouched", int'(pop_data_o), 77);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_push_pop();
    t_underflow();
    t_overflow();
    t_call_ret();
    t_nested();
    t_frame_err();
    t_idle();
    finish_run();
  end
endmodule